// File: doc/BRIEF.md
# Destination Address Filter

This block decides, for each received frame, whether the frame is accepted, based on its 48-bit destination address. Software programs a table of up to sixteen station addresses through a small word-wide register port. Each address is split over a 32-bit high word and the upper half of a 32-bit low word. It also sets one enable bit per table entry and a command word. The command word can admit whole address classes (unicast, multicast, broadcast), can switch table comparison on or off, and can invert the table result.

The receive path presents the six destination bytes together with a one-cycle strobe. One clock later the block returns a registered decision with a valid flag. The decision carries the accept verdict, a flag saying whether an enabled table entry matched, and the index of the lowest-numbered matching entry. Frame parsing beyond the address and all frame check sequence handling belong to other blocks.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every table entry, the enable word and the command word read zero, `dec_valid` is low, and a frame presented before any write is rejected with `dec_hit` low and `dec_index` zero.
- R2: Entry i has its high word at byte offset 8*i and its low word at 8*i+4. The high word holds address bytes 0 to 3, with byte 0 in bits 31:24. The low word holds byte 4 in bits 31:24 and byte 5 in bits 23:16. Bits 15:0 of a low word read zero, and writing them has no effect.
- R3: The enable word sits at byte offset 8*NUM_ENTRIES (0x80 by default). Its bit i enables entry i, and a disabled entry never produces a hit.
- R4: The command word sits at byte offset 8*NUM_ENTRIES+4 (0x84 by default). Bit 0 admits unicast, bit 1 admits multicast, bit 2 admits broadcast, bit 3 inverts the table result, and bit 4 enables table comparison. Bits 31:5 read zero.
- R5: On `da_addr`, byte 0 is bits 47:40 and byte 5 is bits 7:0. An address of all ones is broadcast. An address with bit 40 set that is not broadcast is multicast. An address with bit 40 clear is unicast.
- R6: `dec_hit` is high exactly when table comparison is enabled and at least one enabled entry equals all 48 address bits. `dec_index` is then the lowest such entry index; otherwise `dec_index` is zero.
- R7: `dec_accept` = (compare_enable AND (hit XOR invert)) OR (broadcast AND admit_broadcast) OR (multicast AND admit_multicast) OR (unicast AND admit_unicast).
- R8: A strobe sampled on a clock edge produces `dec_valid` high for exactly the following cycle, so back-to-back strobes give back-to-back decisions. A register write sampled on the same edge as a strobe does not affect that frame's decision.
- R9: Reads of unmapped or unaligned offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | An enabled entry matched while comparison was on |
| dec_index | output | IDX_W (4) | Lowest matching entry index |

## Verification
The bench builds the filter with its default parameters: sixteen entries and an 8-bit register offset. This places the enable and command words directly after the last entry at 0x80 and 0x84. With all sixteen entries in use, the bench can program one address into two enabled entries far apart (2 and 9) to exercise lowest-index priority. It can also place a matching entry at a high index with its enable bit off. The unmapped space from 0x88 upward is available for the ignored-access checks.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

   localparam int DA_W  = 48;
   localparam int CMD_W = 5;

   // Command word, bit 4 down to bit 0
   typedef struct packed {
      logic cam_en;
      logic invert;
      logic acc_bc;
      logic acc_mc;
      logic acc_uc;
   } cmd_t;

   typedef enum logic [1:0] {
      CLS_UNI   = 2'd0,
      CLS_MULTI = 2'd1,
      CLS_BCAST = 2'd2
   } da_class_e;

   function automatic da_class_e classify(input logic [DA_W-1:0] da);
      if (&da)
         return CLS_BCAST;
      else if (da[DA_W-8])
         return CLS_MULTI;
      else
         return CLS_UNI;
   endfunction

endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
   import dafilt_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int REG_AW      = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr,
   input  logic [REG_AW-1:0]                 addr,
   input  logic [31:0]                       wdata,
   output logic [31:0]                       rdata,
   output logic [NUM_ENTRIES-1:0][DA_W-1:0]  ent_addr,
   output logic [NUM_ENTRIES-1:0]            ent_en,
   output cmd_t                              cmd
);

   localparam int                EIDX_W  = REG_AW - 3;
   localparam logic [REG_AW-1:0] EN_OFF  = REG_AW'(NUM_ENTRIES * 8);
   localparam logic [REG_AW-1:0] CMD_OFF = REG_AW'(NUM_ENTRIES * 8 + 4);
   localparam int                LO_W    = DA_W - 32;

   logic                          aligned;
   logic                          sel_en;
   logic                          sel_cmd;
   logic [NUM_ENTRIES-1:0]        sel_hi;
   logic [NUM_ENTRIES-1:0]        sel_lo;
   logic [NUM_ENTRIES-1:0][31:0]  rd_part;
   logic [NUM_ENTRIES-1:0]        en_q;
   cmd_t                          cmd_q;

   assign aligned = (addr[1:0] == 2'b00);
   assign sel_en  = aligned && (addr == EN_OFF);
   assign sel_cmd = aligned && (addr == CMD_OFF);

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      logic [31:0]     hi_q;
      logic [LO_W-1:0] lo_q;

      assign sel_hi[i] = aligned && (addr[REG_AW-1:3] == EIDX_W'(i)) && !addr[2];
      assign sel_lo[i] = aligned && (addr[REG_AW-1:3] == EIDX_W'(i)) &&  addr[2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= '0;
         end else if (wr && sel_hi[i]) begin
            hi_q <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
         end else if (wr && sel_lo[i]) begin
            lo_q <= wdata[31:32-LO_W];
         end
      end

      assign ent_addr[i] = {hi_q, lo_q};
      assign rd_part[i]  = (sel_hi[i] ? hi_q : 32'h0) |
                           (sel_lo[i] ? {lo_q, {(32-LO_W){1'b0}}} : 32'h0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr && sel_en) begin
         en_q <= wdata[NUM_ENTRIES-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr && sel_cmd) begin
         cmd_q <= cmd_t'(wdata[CMD_W-1:0]);
      end
   end

   always_comb begin
      rdata = 32'h0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         rdata = rdata | rd_part[i];
      end
      if (sel_en)
         rdata = rdata | 32'(en_q);
      if (sel_cmd)
         rdata = rdata | 32'(cmd_q);
   end

   assign ent_en = en_q;
   assign cmd    = cmd_q;

endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
   import dafilt_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int IDX_W       = 4
) (
   input  logic [NUM_ENTRIES-1:0][DA_W-1:0] ent_addr,
   input  logic [NUM_ENTRIES-1:0]           ent_en,
   input  logic [DA_W-1:0]                  da,
   output logic                             raw_hit,
   output logic [IDX_W-1:0]                 raw_idx
);

   logic [NUM_ENTRIES-1:0] eq;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      assign eq[i] = ent_en[i] && (ent_addr[i] == da);
   end

   // Scan from the top so that the lowest matching index is kept last
   always_comb begin
      raw_idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (eq[i])
            raw_idx = IDX_W'(i);
      end
   end

   assign raw_hit = |eq;

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
   import dafilt_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  cmd_t             cmd,
   input  logic [DA_W-1:0]  da,
   input  logic             raw_hit,
   input  logic [IDX_W-1:0] raw_idx,
   output logic             accept,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);

   da_class_e cls;
   logic      cam_term;
   logic      class_term;

   assign cls        = classify(da);
   assign hit        = cmd.cam_en && raw_hit;
   assign idx        = hit ? raw_idx : '0;
   assign cam_term   = cmd.cam_en && (raw_hit ^ cmd.invert);

   always_comb begin
      unique case (cls)
         CLS_BCAST: class_term = cmd.acc_bc;
         CLS_MULTI: class_term = cmd.acc_mc;
         default:   class_term = cmd.acc_uc;
      endcase
   end

   assign accept = cam_term || class_term;

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
   import dafilt_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int REG_AW      = 8,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              da_valid,
   input  logic [DA_W-1:0]   da_addr,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic              dec_hit,
   output logic [IDX_W-1:0]  dec_index
);

   initial begin : p_param_check
      if (NUM_ENTRIES < 1 || NUM_ENTRIES > 32)
         $fatal(1, "NUM_ENTRIES must lie in 1..32");
      if (REG_AW < 4 || (NUM_ENTRIES * 8 + 8) > (1 << REG_AW))
         $fatal(1, "REG_AW too small for the register map");
   end

   logic [NUM_ENTRIES-1:0][DA_W-1:0] ent_addr;
   logic [NUM_ENTRIES-1:0]           ent_en;
   cmd_t                             cmd;
   logic                             raw_hit;
   logic [IDX_W-1:0]                 raw_idx;
   logic                             nx_accept;
   logic                             nx_hit;
   logic [IDX_W-1:0]                 nx_idx;

   dafilt_regs #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .REG_AW      (REG_AW)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .ent_addr (ent_addr),
      .ent_en   (ent_en),
      .cmd      (cmd)
   );

   dafilt_match #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .IDX_W       (IDX_W)
   ) u_match (
      .ent_addr (ent_addr),
      .ent_en   (ent_en),
      .da       (da_addr),
      .raw_hit  (raw_hit),
      .raw_idx  (raw_idx)
   );

   dafilt_decide #(
      .IDX_W (IDX_W)
   ) u_decide (
      .cmd     (cmd),
      .da      (da_addr),
      .raw_hit (raw_hit),
      .raw_idx (raw_idx),
      .accept  (nx_accept),
      .hit     (nx_hit),
      .idx     (nx_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
      end else begin
         dec_valid <= da_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_accept <= 1'b0;
         dec_hit    <= 1'b0;
         dec_index  <= '0;
      end else if (da_valid) begin
         dec_accept <= nx_accept;
         dec_hit    <= nx_hit;
         dec_index  <= nx_idx;
      end
   end

endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk #(
   parameter int NUM_ENTRIES = 16,
   parameter int REG_AW      = 8,
   parameter int IDX_W       = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [REG_AW-1:0]      reg_addr,
   input logic [31:0]            reg_rdata,
   input logic                   da_valid,
   input logic [47:0]            da_addr,
   input logic                   dec_valid,
   input logic                   dec_accept,
   input logic                   dec_hit,
   input logic [IDX_W-1:0]       dec_index,
   input logic [NUM_ENTRIES-1:0] ent_en,
   input logic [4:0]             cmd_bits
);

   localparam logic [REG_AW:0]   ENT_END = (REG_AW+1)'(NUM_ENTRIES * 8);
   localparam logic [REG_AW-1:0] CMD_OFF = REG_AW'(NUM_ENTRIES * 8 + 4);

   AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> dec_valid);                                              // R8

   AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !dec_valid);                                            // R8

   AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_hit) |-> ((($past(ent_en) >> dec_index) & 1) != 0)); // R3

   AST_CAM_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !$past(cmd_bits[4])) |-> !dec_hit);                      // R6

   AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && (&da_addr) && cmd_bits[2]) |=> dec_accept);               // R7

   AST_UCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !da_addr[40] && cmd_bits[0]) |=> dec_accept);             // R7

   AST_LO_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (({1'b0, reg_addr} < ENT_END) && (reg_addr[2:0] == 3'b100))
         |-> (reg_rdata[15:0] == 16'h0));                                    // R2

   AST_CMD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CMD_OFF) |-> (reg_rdata[31:5] == 27'h0));                 // R4

endmodule

bind dest_addr_filter dafilt_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .REG_AW      (REG_AW),
   .IDX_W       (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .da_valid   (da_valid),
   .da_addr    (da_addr),
   .dec_valid  (dec_valid),
   .dec_accept (dec_accept),
   .dec_hit    (dec_hit),
   .dec_index  (dec_index),
   .ent_en     (ent_en),
   .cmd_bits   (cmd)
);

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        da_valid = 1'b0;
   logic [47:0] da_addr = '0;
   logic        dec_valid;
   logic        dec_accept;
   logic        dec_hit;
   logic [3:0]  dec_index;

   int n_chk  = 0;
   int n_fail = 0;

   // Model of programmed state, built from the register map in R2..R4
   logic [47:0] m_ent [N];
   logic [15:0] m_en;
   logic [4:0]  m_cmd;

   localparam logic [47:0] A0 = 48'h02_11_22_33_44_55;
   localparam logic [47:0] A1 = 48'h00_AA_BB_CC_DD_EE;
   localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] A2 = 48'h02_11_22_33_44_54;

   always #5 clk = ~clk;

   dest_addr_filter u_dest_addr_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .da_valid   (da_valid),
      .da_addr    (da_addr),
      .dec_valid  (dec_valid),
      .dec_accept (dec_accept),
      .dec_hit    (dec_hit),
      .dec_index  (dec_index)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
      if (a[1:0] != 2'b00) return;
      if (a < 8'(N * 8)) begin
         if (a[2]) m_ent[a >> 3][15:0]  = d[31:16];
         else      m_ent[a >> 3][47:16] = d;
      end else if (a == 8'(N * 8)) begin
         m_en = d[15:0];
      end else if (a == 8'(N * 8 + 4)) begin
         m_cmd = d[4:0];
      end
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      if (a < 8'(N * 8))
         return a[2] ? {m_ent[a >> 3][15:0], 16'h0} : m_ent[a >> 3][47:16];
      if (a == 8'(N * 8))     return {16'h0, m_en};
      if (a == 8'(N * 8 + 4)) return {27'h0, m_cmd};
      return 32'h0;
   endfunction

   // Expected decision {accept, hit, index} from R5..R7
   function automatic logic [5:0] model_decide(input logic [47:0] da);
      logic       raw = 1'b0;
      logic [3:0] ix  = 4'd0;
      logic       bc, mc, uc, hit, acc;
      for (int i = N - 1; i >= 0; i--) begin
         if (m_en[i] && m_ent[i] == da) begin
            raw = 1'b1;
            ix  = 4'(i);
         end
      end
      bc  = (da == BC);
      mc  = da[40] && !bc;
      uc  = !da[40];
      hit = m_cmd[4] && raw;
      acc = (m_cmd[4] && (raw ^ m_cmd[3])) || (bc && m_cmd[2]) ||
            (mc && m_cmd[1]) || (uc && m_cmd[0]);
      return {acc, hit, hit ? ix : 4'd0};
   endfunction

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
      model_write(a, d);
   endtask

   task automatic reg_check(input string req, input logic [7:0] a);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, $sformatf("read 0x%02h", a), 64'(reg_rdata), 64'(model_read(a)));
   endtask

   task automatic frame_check(input string req, input logic [47:0] da);
      logic [5:0] e;
      @(negedge clk);
      da_valid = 1'b1;
      da_addr  = da;
      e = model_decide(da);
      @(negedge clk);
      da_valid = 1'b0;
      chk(req, "dec_valid",  64'(dec_valid),  64'(1));
      chk(req, "dec_accept", 64'(dec_accept), 64'(e[5]));
      chk(req, "dec_hit",    64'(dec_hit),    64'(e[4]));
      chk(req, "dec_index",  64'(dec_index),  64'(e[3:0]));
   endtask

   task automatic program_entry(input int i, input logic [47:0] a);
      reg_write(8'(i * 8),     a[47:16]);
      reg_write(8'(i * 8 + 4), {a[15:0], 16'hBEEF});
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "dec_valid at reset", 64'(dec_valid), 64'(0));
      reg_check("R1", 8'h28);
      reg_check("R1", 8'h2C);
      reg_check("R1", 8'h80);
      reg_check("R1", 8'h84);
      frame_check("R1", A0);
      chk("R1", "accept after reset", 64'(dec_accept), 64'(0));
   endtask

   task automatic t_regmap();
      program_entry(3, 48'hC0_FF_EE_12_34_56);
      reg_check("R2", 8'h18);
      reg_check("R2", 8'h1C);
      @(negedge clk);
      reg_addr = 8'h18; #1;
      chk("R2", "byte0 at 31:24", 64'(reg_rdata[31:24]), 64'(8'hC0));
      reg_addr = 8'h1C; #1;
      chk("R2", "low pad zero", 64'(reg_rdata[15:0]), 64'(0));
      reg_write(8'h84, 32'hFFFF_FFE0);
      reg_check("R4", 8'h84);
      reg_write(8'h84, 32'h0);
      reg_write(8'h90, 32'hFFFF_FFFF);
      reg_write(8'h19, 32'h1234_5678);
      reg_check("R9", 8'h90);
      reg_check("R9", 8'h19);
      reg_check("R9", 8'h18);
      reg_check("R9", 8'h80);
      reg_check("R9", 8'h84);
   endtask

   task automatic t_cam();
      program_entry(5, A0);
      program_entry(2, A1);
      program_entry(9, A1);
      program_entry(12, MC);
      reg_write(8'h80, 32'h0000_0224);   // entries 2, 5, 9
      reg_write(8'h84, 32'h0000_0010);
      frame_check("R6", A0);
      chk("R6", "index of A0", 64'(dec_index), 64'(5));
      frame_check("R6", A1);
      chk("R6", "lowest index wins", 64'(dec_index), 64'(2));
      frame_check("R6", A2);
      frame_check("R3", MC);
      chk("R3", "disabled entry no hit", 64'(dec_hit), 64'(0));
      reg_write(8'h80, 32'h0000_0200);   // only entry 9
      frame_check("R3", A1);
      chk("R3", "index after disable", 64'(dec_index), 64'(9));
      reg_write(8'h80, 32'h0000_0224);
      reg_write(8'h84, 32'h0000_0000);
      frame_check("R6", A0);
      chk("R6", "compare off no hit", 64'(dec_hit), 64'(0));
   endtask

   task automatic t_classes();
      reg_write(8'h84, 32'h0000_0001);
      frame_check("R5", A2);
      frame_check("R5", MC);
      frame_check("R5", BC);
      reg_write(8'h84, 32'h0000_0002);
      frame_check("R5", MC);
      frame_check("R5", BC);
      chk("R5", "broadcast not multicast", 64'(dec_accept), 64'(0));
      reg_write(8'h84, 32'h0000_0004);
      frame_check("R7", BC);
      frame_check("R7", 48'hFF_FF_FF_FF_FF_FE);
   endtask

   task automatic t_invert();
      reg_write(8'h84, 32'h0000_0018);
      frame_check("R7", A0);
      chk("R7", "inverted hit rejects", 64'(dec_accept), 64'(0));
      frame_check("R7", A2);
      chk("R7", "inverted miss accepts", 64'(dec_accept), 64'(1));
      reg_write(8'h84, 32'h0000_0008);
      frame_check("R7", A2);
      reg_write(8'h84, 32'h0000_001A);
      frame_check("R7", MC);
   endtask

   task automatic t_timing();
      logic [5:0] e0, e1;
      reg_write(8'h84, 32'h0000_0010);
      @(negedge clk);
      da_valid = 1'b1; da_addr = A0; e0 = model_decide(A0);
      @(negedge clk);
      chk("R8", "b2b first valid", 64'(dec_valid), 64'(1));
      chk("R8", "b2b first index", 64'(dec_index), 64'(e0[3:0]));
      da_addr = A1; e1 = model_decide(A1);
      @(negedge clk);
      da_valid = 1'b0;
      chk("R8", "b2b second valid", 64'(dec_valid), 64'(1));
      chk("R8", "b2b second index", 64'(dec_index), 64'(e1[3:0]));
      @(negedge clk);
      chk("R8", "valid drops", 64'(dec_valid), 64'(0));
      // Write landing on the same edge as a strobe: frame uses old table
      da_valid = 1'b1; da_addr = A0; e0 = model_decide(A0);
      reg_wr = 1'b1; reg_addr = 8'h80; reg_wdata = 32'h0000_0004;
      @(negedge clk);
      da_valid = 1'b0; reg_wr = 1'b0;
      model_write(8'h80, 32'h0000_0004);
      chk("R8", "same-edge accept", 64'(dec_accept), 64'(e0[5]));
      chk("R8", "same-edge hit", 64'(dec_hit), 64'(1));
      frame_check("R8", A0);
      chk("R8", "after write no hit", 64'(dec_hit), 64'(0));
   endtask

   initial begin
      for (int i = 0; i < N; i++) m_ent[i] = '0;
      m_en  = '0;
      m_cmd = '0;
      #22;
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_cam();
      t_classes();
      t_invert();
      t_timing();
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

endmodule